// File: doc/BRIEF.md
# Emergency Power Reduction Controller

This controller decides, for a whole device, when the datapath must drop into an emergency low-power state and when it may come back. Four causes can request the state: a chassis power-brake wire (active low, asynchronous to the core clock), a software request bit, a vendor-specific request and an autonomous request from on-chip detectors. Two strap inputs are captured once after reset. They are a two-bit support level and an init-required flag, and together they decide which causes are honoured.

The brake wire is synchronized, and its assertion is passed on at once so that the entry deadline of a few microseconds is met. Its release must stay stable for a parameterized number of clocks before it counts as inactive, which filters bounce on a wire whose phases last at least a millisecond. A sticky detected flag records that the state was entered. Software clears it by writing 1, and the clear is refused while any cause is still active. When the init-required strap is set, every exit raises a one-cycle pulse that asks for re-initialization.

A small register port exposes status, control and capability words. Reads are combinational. Writes take effect at the next clock edge.

Top module: `epr_ctrl`

## Requirements
- R1: After `brake_n` falls with support level 10, `reduce_state` is 1 after the (SYNC_STAGES+1)-th rising clock edge and 0 before it.
- R2: After `brake_n` returns high, `reduce_state` stays 1 for SYNC_STAGES+EXIT_CYC edges and drops at edge SYNC_STAGES+1+EXIT_CYC. A high phase shorter than EXIT_CYC cycles causes no exit.
- R3: The state is left only when no enabled cause remains. Clearing the software request while another enabled cause is active keeps the state.
- R4: Gating by support level: 10 honours the pin, software and vendor/autonomous causes; 01 honours software and vendor/autonomous but not the pin; 00 with init 0 honours only vendor/autonomous; 00 with init 1 honours none; 11 behaves as 00.
- R5: Control word (address 1), bit 11 is the software request. It resets to 0, is writable only when the support level is 01 or 10, and otherwise reads 0 and has no effect.
- R6: Status word (address 0), bit 6 is the detected flag. It sets on entry, resets to 0 and is cleared by writing 1 only while no cause is active and the state is off. It reads 0 when the support level is 00 or 11.
- R7: Capability word (address 2) holds the support level in bits 25:24 and init-required in bit 26. Both are captured from the straps once after reset and do not follow later strap changes. Address 3 reads 0.
- R8: When init-required is 1, each exit from the state raises `reinit_req` for exactly one cycle, in the cycle `reduce_state` first reads 0. When init-required is 0, no pulse is raised.
- R9: After reset, `reduce_state` and `reinit_req` are 0 and the status and control words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| brake_n | input | 1 | Chassis power-brake wire, active low, asynchronous |
| vendor_req | input | 1 | Vendor-specific request, synchronous |
| auto_req | input | 1 | Autonomous detector request, synchronous |
| strap_support | input | 2 | Support level strap |
| strap_init | input | 1 | Init-required strap |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| reduce_state | output | 1 | Emergency low-power state to the datapath |
| reinit_req | output | 1 | One-cycle re-initialization request on exit |

## Verification
The bench measures the entry latency and the exit delay edge by edge. A design that debounced entry, or that let go early, would miss those cycles. A short high glitch on the brake wire during the state is applied, and a filter that restarted or skipped its count would drop the state. Each support level and init combination is tried with the pin and with each request source, so a gate that honoured the pin under 01, or honoured anything under 00 with init set, shows up as a wrong state. Clearing the detected flag while the cause is still active, strap changes after reset, and the presence or absence of the exit pulse catch a flag that clears too eagerly, capability bits that follow the straps, and a pulse that is missing, stretched or fired without init-required.

// File: rtl/epr_pkg.sv
package epr_pkg;
  typedef enum logic [1:0] {
    SUP_NONE = 2'b00,
    SUP_DEV  = 2'b01,
    SUP_ALL  = 2'b10,
    SUP_RSV  = 2'b11
  } sup_e;

  localparam logic [1:0] ADDR_STS = 2'd0;
  localparam logic [1:0] ADDR_CTL = 2'd1;
  localparam logic [1:0] ADDR_CAP = 2'd2;

  localparam int REG_W        = 32;
  localparam int STS_DET_BIT  = 6;
  localparam int CTL_REQ_BIT  = 11;
  localparam int CAP_SUP_LSB  = 24;
  localparam int CAP_INIT_BIT = 26;
endpackage

// File: rtl/epr_sync.sv
module epr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d_async};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/epr_exit_filter.sv
module epr_exit_filter #(
  parameter int EXIT_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_in,
  output logic act_out
);
  localparam int CW = $clog2(EXIT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(EXIT_CYC - 1);

  logic          hold_q, hold_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    hold_d = hold_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (act_in) begin
      hold_d = 1'b1;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (hold_q) begin
      cnt_en = 1'b1;
      if (cnt_q == LAST) begin
        hold_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      hold_q <= hold_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // entry passes straight through, release is held
  assign act_out = act_in | hold_q;
endmodule

// File: rtl/epr_trig_gate.sv
module epr_trig_gate
  import epr_pkg::*;
(
  input  logic [1:0] sup,
  input  logic       init_req,
  input  logic       pin_act,
  input  logic       sw_req,
  input  logic       vendor_req,
  input  logic       auto_req,
  output logic       cause,
  output logic       sw_en
);
  sup_e sup_eff;
  logic pin_en, dev_en;

  always_comb begin
    sup_eff = (sup_e'(sup) == SUP_RSV) ? SUP_NONE : sup_e'(sup);
    pin_en  = (sup_eff == SUP_ALL);
    sw_en   = (sup_eff != SUP_NONE);
    dev_en  = sw_en | ~init_req;
    cause   = (pin_en & pin_act) | (sw_en & sw_req) |
              (dev_en & (vendor_req | auto_req));
  end
endmodule

// File: rtl/epr_ctrl.sv
module epr_ctrl
  import epr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int EXIT_CYC    = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             brake_n,
  input  logic             vendor_req,
  input  logic             auto_req,
  input  logic [1:0]       strap_support,
  input  logic             strap_init,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             reduce_state,
  output logic             reinit_req
);
  logic rst_s_n;
  logic brake_s_n, pin_act, pin_f;
  logic cause, sw_en;

  logic       cap_valid_q, cap_valid_d;
  logic [1:0] cap_sup_q, cap_sup_d;
  logic       cap_init_q, cap_init_d;
  logic       cap_en;
  logic       sw_req_q, sw_req_d, sw_we;
  logic       det_q, det_d;
  logic       reduce_q, reinit_q, reinit_d;
  logic       w1c;
  logic       unused_wdata;

  epr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_async(1'b1), .q(rst_s_n));

  epr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_brake_sync (
    .clk(clk), .rst_n(rst_s_n), .d_async(brake_n), .q(brake_s_n));

  assign pin_act = ~brake_s_n;

  epr_exit_filter #(.EXIT_CYC(EXIT_CYC)) u_filter (
    .clk(clk), .rst_n(rst_s_n), .act_in(pin_act), .act_out(pin_f));

  epr_trig_gate u_gate (
    .sup(cap_sup_q), .init_req(cap_init_q), .pin_act(pin_f),
    .sw_req(sw_req_q), .vendor_req(vendor_req), .auto_req(auto_req),
    .cause(cause), .sw_en(sw_en));

  always_comb begin
    cap_en      = ~cap_valid_q;
    cap_valid_d = 1'b1;
    cap_sup_d   = strap_support;
    cap_init_d  = strap_init;

    sw_we    = reg_wr & (reg_addr == ADDR_CTL) & sw_en;
    sw_req_d = reg_wdata[CTL_REQ_BIT];

    w1c = reg_wr & (reg_addr == ADDR_STS) & reg_wdata[STS_DET_BIT];
    if (cause | reduce_q) det_d = 1'b1;
    else if (w1c)         det_d = 1'b0;
    else                  det_d = det_q;

    reinit_d = reduce_q & ~cause & cap_init_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cap_valid_q <= 1'b0;
      cap_sup_q   <= 2'b00;
      cap_init_q  <= 1'b0;
      sw_req_q    <= 1'b0;
      det_q       <= 1'b0;
      reduce_q    <= 1'b0;
      reinit_q    <= 1'b0;
    end else begin
      if (cap_en) begin
        cap_valid_q <= cap_valid_d;
        cap_sup_q   <= cap_sup_d;
        cap_init_q  <= cap_init_d;
      end
      if (sw_we) sw_req_q <= sw_req_d;
      det_q    <= det_d;
      reduce_q <= cause;
      reinit_q <= reinit_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_STS: reg_rdata[STS_DET_BIT] = det_q & sw_en;
      ADDR_CTL: reg_rdata[CTL_REQ_BIT] = sw_req_q & sw_en;
      ADDR_CAP: begin
        reg_rdata[CAP_SUP_LSB +: 2] = cap_sup_q;
        reg_rdata[CAP_INIT_BIT]     = cap_init_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign unused_wdata = ^reg_wdata;
  assign reduce_state = reduce_q;
  assign reinit_req   = reinit_q;
endmodule

// File: rtl/epr_ctrl_chk.sv
module epr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_act,
  input logic       cap_valid,
  input logic [1:0] cap_sup,
  input logic       reduce_state,
  input logic       det,
  input logic       reinit_req
);
  // R1: synchronized pin under full support forces the state next cycle
  a_r1_pin_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && cap_sup == 2'b10 && pin_act) |=> reduce_state);

  // R2: the state survives the cycle after the pin goes inactive
  a_r2_release_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && cap_sup == 2'b10 && $fell(pin_act)) |=> reduce_state);

  // R6: being in the state leaves the detected flag set
  a_r6_det_follows: assert property (@(posedge clk) disable iff (!rst_n)
    reduce_state |=> det);

  // R7: captured support level never moves once valid
  a_r7_cap_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && $past(cap_valid)) |-> $stable(cap_sup));

  // R8: the re-init pulse is single-cycle
  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_req |=> !reinit_req);

  // R8: the pulse appears only as the state is left
  a_r8_pulse_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_req |-> (!reduce_state && $past(reduce_state)));
endmodule

bind epr_ctrl epr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_s_n), .pin_act(pin_act), .cap_valid(cap_valid_q),
  .cap_sup(cap_sup_q), .reduce_state(reduce_state), .det(det_q),
  .reinit_req(reinit_req));

// File: tb/tb_epr_ctrl.sv
module tb_epr_ctrl;
  localparam int SYNC = 2;
  localparam int EXIT = 16;

  logic        clk, rst_n, brake_n, vendor_req, auto_req;
  logic [1:0]  strap_support;
  logic        strap_init, reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reduce_state, reinit_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  epr_ctrl #(.SYNC_STAGES(SYNC), .EXIT_CYC(EXIT)) dut (
    .clk(clk), .rst_n(rst_n), .brake_n(brake_n), .vendor_req(vendor_req),
    .auto_req(auto_req), .strap_support(strap_support), .strap_init(strap_init),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reduce_state(reduce_state), .reinit_req(reinit_req));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    cyc(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic do_reset(input logic [1:0] sup, input logic init);
    @(negedge clk);
    rst_n = 1'b0; strap_support = sup; strap_init = init;
    brake_n = 1'b1; vendor_req = 1'b0; auto_req = 1'b0;
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    cyc(2);
    rst_n = 1'b1;
    cyc(6);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset(2'b10, 1'b1);
    chk("R9 reduce", {31'd0, reduce_state}, 32'd0);
    chk("R9 reinit", {31'd0, reinit_req}, 32'd0);
    rd(2'd0, d); chk("R9 status", d, 32'd0);
    rd(2'd1, d); chk("R9 control", d, 32'd0);
  endtask

  task automatic t_pin_cycle();
    logic [31:0] d;
    do_reset(2'b10, 1'b1);
    brake_n = 1'b0;
    cyc(SYNC);
    chk("R1 before latency", {31'd0, reduce_state}, 32'd0);
    cyc(1);
    chk("R1 entry", {31'd0, reduce_state}, 32'd1);
    rd(2'd0, d); chk("R6 set on entry", d, 32'h40);
    wr(2'd0, 32'h40);
    rd(2'd0, d); chk("R6 clear refused", d, 32'h40);
    brake_n = 1'b1;
    cyc(SYNC + EXIT);
    chk("R2 held", {31'd0, reduce_state}, 32'd1);
    chk("R8 no early pulse", {31'd0, reinit_req}, 32'd0);
    cyc(1);
    chk("R2 exit", {31'd0, reduce_state}, 32'd0);
    chk("R8 pulse", {31'd0, reinit_req}, 32'd1);
    cyc(1);
    chk("R8 pulse ends", {31'd0, reinit_req}, 32'd0);
    rd(2'd0, d); chk("R6 sticky after exit", d, 32'h40);
    wr(2'd0, 32'h40);
    rd(2'd0, d); chk("R6 cleared", d, 32'd0);
  endtask

  task automatic t_bounce();
    do_reset(2'b10, 1'b0);
    brake_n = 1'b0;
    cyc(SYNC + 2);
    chk("R2 entered", {31'd0, reduce_state}, 32'd1);
    brake_n = 1'b1;
    cyc(EXIT / 2);
    chk("R2 mid glitch", {31'd0, reduce_state}, 32'd1);
    brake_n = 1'b0;
    cyc(SYNC + 2);
    chk("R2 glitch ignored", {31'd0, reduce_state}, 32'd1);
    brake_n = 1'b1;
    cyc(SYNC + EXIT + 1);
    chk("R2 final exit", {31'd0, reduce_state}, 32'd0);
    chk("R8 no pulse init0", {31'd0, reinit_req}, 32'd0);
  endtask

  task automatic t_gating();
    logic [31:0] d;
    do_reset(2'b01, 1'b0);
    brake_n = 1'b0; cyc(SYNC + 6);
    chk("R4 pin ignored under 01", {31'd0, reduce_state}, 32'd0);
    brake_n = 1'b1; vendor_req = 1'b1; cyc(1);
    chk("R4 vendor under 01", {31'd0, reduce_state}, 32'd1);
    vendor_req = 1'b0; cyc(1);
    chk("R4 vendor release 01", {31'd0, reduce_state}, 32'd0);

    do_reset(2'b00, 1'b1);
    vendor_req = 1'b1; auto_req = 1'b1; cyc(2);
    chk("R4 none under 00 init1", {31'd0, reduce_state}, 32'd0);
    vendor_req = 1'b0; auto_req = 1'b0;
    wr(2'd1, 32'h800); cyc(1);
    rd(2'd1, d); chk("R5 control ignored under 00", d, 32'd0);
    chk("R5 no entry under 00", {31'd0, reduce_state}, 32'd0);

    do_reset(2'b00, 1'b0);
    auto_req = 1'b1; cyc(1);
    chk("R4 auto under 00 init0", {31'd0, reduce_state}, 32'd1);
    rd(2'd0, d); chk("R6 hidden under 00", d, 32'd0);
    auto_req = 1'b0; cyc(1);
    chk("R4 auto release", {31'd0, reduce_state}, 32'd0);

    do_reset(2'b11, 1'b0);
    brake_n = 1'b0; cyc(SYNC + 6);
    chk("R4 pin ignored under 11", {31'd0, reduce_state}, 32'd0);
    brake_n = 1'b1; vendor_req = 1'b1; cyc(1);
    chk("R4 vendor under 11", {31'd0, reduce_state}, 32'd1);
    vendor_req = 1'b0; cyc(1);
  endtask

  task automatic t_sw_req();
    logic [31:0] d;
    do_reset(2'b10, 1'b0);
    wr(2'd1, 32'h800);
    rd(2'd1, d); chk("R5 readback", d, 32'h800);
    cyc(1);
    chk("R5 entry by sw", {31'd0, reduce_state}, 32'd1);
    vendor_req = 1'b1;
    wr(2'd1, 32'd0);
    cyc(2);
    chk("R3 held by vendor", {31'd0, reduce_state}, 32'd1);
    wr(2'd0, 32'h40);
    rd(2'd0, d); chk("R6 clear refused vendor", d, 32'h40);
    vendor_req = 1'b0;
    cyc(1);
    chk("R3 exit when clear", {31'd0, reduce_state}, 32'd0);
    chk("R8 no pulse init0 sw", {31'd0, reinit_req}, 32'd0);
  endtask

  task automatic t_cap();
    logic [31:0] d;
    do_reset(2'b10, 1'b1);
    rd(2'd2, d); chk("R7 capability", d, 32'h0600_0000);
    strap_support = 2'b01; strap_init = 1'b0;
    cyc(3);
    rd(2'd2, d); chk("R7 straps frozen", d, 32'h0600_0000);
    rd(2'd3, d); chk("R7 addr3 zero", d, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; brake_n = 1'b1; vendor_req = 1'b0; auto_req = 1'b0;
    strap_support = 2'b00; strap_init = 1'b0;
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    t_reset_state();
    t_pin_cycle();
    t_bounce();
    t_gating();
    t_sw_req();
    t_cap();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule